// File: doc/BRIEF.md
# RISC Instruction Decoder and Control Generator

This block takes one 32-bit fixed-length instruction word and, with no clock and no state, breaks it into its register, shift, immediate and jump-target fields and produces the control signals a single-issue integer datapath needs. Those signals are the register write enable, the destination choice, the ALU operation and operand source, the immediate extension mode, the memory access controls, the branch and jump flags, and a flag for an illegal instruction. It also forms the 32-bit extended immediate and the resolved destination register index, so the datapath gets them without further logic.

The decoded subset is integer arithmetic (add, subtract, set-less-than), immediate arithmetic and logic (add, or, set-less-than, load-upper), word and byte loads and stores, equal and not-equal branches, and plain, linking and register jumps. The top 6 bits always carry the opcode. Opcode 0 selects the register format, and its low 6 bits (funct) then choose the operation. Any encoding outside this set is reported as illegal, and every side effect is held off. The register file, ALU, memory and next-PC logic sit outside the block.

Top module: `risc_ctrl_decoder`

## Requirements
- R1: Fields are split at fixed positions: rs = bits [25:21], rt = [20:16], shamt = [10:6], jump target = [25:0]. All of them appear on the outputs for every instruction, whether it is legal or not.
- R2: With opcode 0, funct 32 (add), 34 (subtract) or 42 (set-less-than) gives a register write to rd (dst_sel 0, dst_addr = bits [15:11]) with register operand source. The ALU codes are add=0, subtract=1, set-less-than=3.
- R3: With opcode 0, funct 8 (jump-register) raises jump_reg and writes no register.
- R4: Opcodes 8 (add-imm, ALU 0, sign mode 0), 10 (slt-imm, ALU 3, sign mode 0) and 13 (or-imm, ALU 2, zero mode 1) write rt (dst_sel 1) and take the immediate as ALU source.
- R5: Opcode 15 (load-upper) writes rt with ALU code 4 (pass operand B), the immediate as source and upper mode 2.
- R6: The extended immediate is the 16-bit field sign-extended in mode 0, zero-extended in mode 1, and placed in bits [31:16] with zeros below in mode 2.
- R7: Opcodes 35 (load word) and 32 (load byte) raise mem_rd and write rt, with ALU add, immediate source and sign mode. mem_byte is 1 only for opcode 32.
- R8: Opcodes 43 (store word) and 40 (store byte) raise mem_wr and never write a register. mem_byte is 1 only for opcode 40, and mem_rd and mem_wr are never high together.
- R9: Opcodes 4 and 5 raise br_eq and br_ne respectively, with ALU subtract, register source and sign mode. They write no register.
- R10: Opcode 2 raises jump only. Opcode 3 raises jump and link and writes register 31 (dst_sel 2, dst_addr 31).
- R11: Any other opcode, and opcode 0 with any other funct, raises illegal. Every control output then sits at its idle value: all flags 0, ALU code 0, dst_sel 0, mode 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs_addr_o | output | 5 | First source register index |
| rt_addr_o | output | 5 | Second source register index |
| dst_addr_o | output | 5 | Resolved destination register index |
| shamt_o | output | 5 | Shift amount field |
| imm_ext_o | output | 32 | Immediate extended per the selected mode |
| jtarget_o | output | 26 | Jump target field |
| reg_we_o | output | 1 | Register write enable |
| dst_sel_o | output | 2 | Destination choice: 0 rd, 1 rt, 2 link register |
| alu_op_o | output | 3 | ALU operation: 0 add, 1 sub, 2 or, 3 slt, 4 pass B |
| alu_src_imm_o | output | 1 | ALU operand B is the immediate |
| imm_mode_o | output | 2 | Extension: 0 sign, 1 zero, 2 upper |
| mem_rd_o | output | 1 | Memory read |
| mem_wr_o | output | 1 | Memory write |
| mem_byte_o | output | 1 | Memory access is a byte (else a word) |
| br_eq_o | output | 1 | Branch if equal |
| br_ne_o | output | 1 | Branch if not equal |
| jump_o | output | 1 | Jump to the target field |
| jump_reg_o | output | 1 | Jump to a register value |
| link_o | output | 1 | Jump saves the return address |
| illegal_o | output | 1 | Encoding not in the decoded set |

## Verification
Every legal opcode is applied, and each register-format funct under opcode 0, each with distinct register fields. This shows that every control bundle goes with exactly one encoding, and that rd, rt and the link index are chosen correctly. Immediates with bit 15 set and clear are driven through the sign, zero and upper modes, which tells the three extension paths apart. Unused opcodes at both ends of the range, a register-format word with funct 0, and an unused funct next to a valid one show that illegal encodings leave every side effect low while the raw fields still pass through.

// File: rtl/rdec_pkg.sv
package rdec_pkg;

    localparam int unsigned INSTR_W = 32;
    localparam int unsigned OPC_W   = 6;
    localparam int unsigned FN_W    = 6;
    localparam int unsigned RA_W    = 5;
    localparam int unsigned IMM_W   = 16;
    localparam int unsigned TGT_W   = 26;

    localparam logic [OPC_W-1:0] OPC_REG   = 6'd0;
    localparam logic [OPC_W-1:0] OPC_JMP   = 6'd2;
    localparam logic [OPC_W-1:0] OPC_JAL   = 6'd3;
    localparam logic [OPC_W-1:0] OPC_BEQ   = 6'd4;
    localparam logic [OPC_W-1:0] OPC_BNE   = 6'd5;
    localparam logic [OPC_W-1:0] OPC_ADDI  = 6'd8;
    localparam logic [OPC_W-1:0] OPC_SLTI  = 6'd10;
    localparam logic [OPC_W-1:0] OPC_ORI   = 6'd13;
    localparam logic [OPC_W-1:0] OPC_LUI   = 6'd15;
    localparam logic [OPC_W-1:0] OPC_LDB   = 6'd32;
    localparam logic [OPC_W-1:0] OPC_LDW   = 6'd35;
    localparam logic [OPC_W-1:0] OPC_STB   = 6'd40;
    localparam logic [OPC_W-1:0] OPC_STW   = 6'd43;

    localparam logic [FN_W-1:0]  FN_JREG   = 6'd8;
    localparam logic [FN_W-1:0]  FN_ADD    = 6'd32;
    localparam logic [FN_W-1:0]  FN_SUB    = 6'd34;
    localparam logic [FN_W-1:0]  FN_SLT    = 6'd42;

    typedef enum logic [2:0] {
        ALU_ADD   = 3'd0,
        ALU_SUB   = 3'd1,
        ALU_OR    = 3'd2,
        ALU_SLT   = 3'd3,
        ALU_PASSB = 3'd4
    } alu_op_e;

    typedef enum logic [1:0] {
        EXT_SIGN  = 2'd0,
        EXT_ZERO  = 2'd1,
        EXT_UPPER = 2'd2
    } ext_mode_e;

    typedef enum logic [1:0] {
        DST_RD   = 2'd0,
        DST_RT   = 2'd1,
        DST_LINK = 2'd2
    } dst_sel_e;

    typedef struct packed {
        logic      reg_we;
        dst_sel_e  dst_sel;
        alu_op_e   alu_op;
        logic      alu_src_imm;
        ext_mode_e ext_mode;
        logic      mem_rd;
        logic      mem_wr;
        logic      mem_byte;
        logic      br_eq;
        logic      br_ne;
        logic      jump;
        logic      jump_reg;
        logic      link;
    } ctrl_t;

    localparam ctrl_t CTRL_IDLE = '{
        reg_we:      1'b0,
        dst_sel:     DST_RD,
        alu_op:      ALU_ADD,
        alu_src_imm: 1'b0,
        ext_mode:    EXT_SIGN,
        mem_rd:      1'b0,
        mem_wr:      1'b0,
        mem_byte:    1'b0,
        br_eq:       1'b0,
        br_ne:       1'b0,
        jump:        1'b0,
        jump_reg:    1'b0,
        link:        1'b0
    };

endpackage

// File: rtl/rdec_fields.sv
module rdec_fields #(
    parameter int unsigned INSTR_W = 32,
    parameter int unsigned OPC_W   = 6,
    parameter int unsigned FN_W    = 6,
    parameter int unsigned RA_W    = 5,
    parameter int unsigned IMM_W   = 16,
    parameter int unsigned TGT_W   = 26
) (
    input  logic [INSTR_W-1:0] instr_i,
    output logic [OPC_W-1:0]   opcode_o,
    output logic [RA_W-1:0]    rs_o,
    output logic [RA_W-1:0]    rt_o,
    output logic [RA_W-1:0]    rd_o,
    output logic [RA_W-1:0]    shamt_o,
    output logic [FN_W-1:0]    funct_o,
    output logic [IMM_W-1:0]   imm_o,
    output logic [TGT_W-1:0]   target_o
);
    // Field boundaries counted down from the top of the word.
    localparam int unsigned OPC_LSB = INSTR_W - OPC_W;
    localparam int unsigned RS_LSB  = OPC_LSB - RA_W;
    localparam int unsigned RT_LSB  = RS_LSB - RA_W;
    localparam int unsigned RD_LSB  = RT_LSB - RA_W;
    localparam int unsigned SH_LSB  = RD_LSB - RA_W;

    assign opcode_o = instr_i[OPC_LSB +: OPC_W];
    assign rs_o     = instr_i[RS_LSB  +: RA_W];
    assign rt_o     = instr_i[RT_LSB  +: RA_W];
    assign rd_o     = instr_i[RD_LSB  +: RA_W];
    assign shamt_o  = instr_i[SH_LSB  +: RA_W];
    assign funct_o  = instr_i[0 +: FN_W];
    assign imm_o    = instr_i[0 +: IMM_W];
    assign target_o = instr_i[0 +: TGT_W];
endmodule

// File: rtl/rdec_funct_dec.sv
module rdec_funct_dec
    import rdec_pkg::*;
(
    input  logic [FN_W-1:0] funct_i,
    output ctrl_t           ctrl_o,
    output logic            hit_o
);
    ctrl_t ctrl_d;
    logic  hit_d;

    always_comb begin
        ctrl_d = CTRL_IDLE;
        hit_d  = 1'b1;
        unique case (funct_i)
            FN_ADD: begin
                ctrl_d.reg_we  = 1'b1;
                ctrl_d.dst_sel = DST_RD;
                ctrl_d.alu_op  = ALU_ADD;
            end
            FN_SUB: begin
                ctrl_d.reg_we  = 1'b1;
                ctrl_d.dst_sel = DST_RD;
                ctrl_d.alu_op  = ALU_SUB;
            end
            FN_SLT: begin
                ctrl_d.reg_we  = 1'b1;
                ctrl_d.dst_sel = DST_RD;
                ctrl_d.alu_op  = ALU_SLT;
            end
            FN_JREG: begin
                ctrl_d.jump_reg = 1'b1;
            end
            default: begin
                hit_d = 1'b0;
            end
        endcase
    end

    assign ctrl_o = ctrl_d;
    assign hit_o  = hit_d;
endmodule

// File: rtl/rdec_opcode_dec.sv
module rdec_opcode_dec
    import rdec_pkg::*;
(
    input  logic [OPC_W-1:0] opcode_i,
    output ctrl_t            ctrl_o,
    output logic             hit_o,
    output logic             regfmt_o
);
    ctrl_t ctrl_d;
    logic  hit_d;
    logic  regfmt_d;

    always_comb begin
        ctrl_d   = CTRL_IDLE;
        hit_d    = 1'b1;
        regfmt_d = 1'b0;
        unique case (opcode_i)
            OPC_REG: begin
                regfmt_d = 1'b1;
                hit_d    = 1'b0;
            end
            OPC_ADDI, OPC_SLTI, OPC_ORI: begin
                ctrl_d.reg_we      = 1'b1;
                ctrl_d.dst_sel     = DST_RT;
                ctrl_d.alu_src_imm = 1'b1;
                if (opcode_i == OPC_ORI) begin
                    ctrl_d.alu_op   = ALU_OR;
                    ctrl_d.ext_mode = EXT_ZERO;
                end else if (opcode_i == OPC_SLTI) begin
                    ctrl_d.alu_op   = ALU_SLT;
                end else begin
                    ctrl_d.alu_op   = ALU_ADD;
                end
            end
            OPC_LUI: begin
                ctrl_d.reg_we      = 1'b1;
                ctrl_d.dst_sel     = DST_RT;
                ctrl_d.alu_src_imm = 1'b1;
                ctrl_d.alu_op      = ALU_PASSB;
                ctrl_d.ext_mode    = EXT_UPPER;
            end
            OPC_LDW, OPC_LDB: begin
                ctrl_d.reg_we      = 1'b1;
                ctrl_d.dst_sel     = DST_RT;
                ctrl_d.alu_src_imm = 1'b1;
                ctrl_d.mem_rd      = 1'b1;
                ctrl_d.mem_byte    = (opcode_i == OPC_LDB);
            end
            OPC_STW, OPC_STB: begin
                ctrl_d.alu_src_imm = 1'b1;
                ctrl_d.mem_wr      = 1'b1;
                ctrl_d.mem_byte    = (opcode_i == OPC_STB);
            end
            OPC_BEQ, OPC_BNE: begin
                ctrl_d.alu_op = ALU_SUB;
                ctrl_d.br_eq  = (opcode_i == OPC_BEQ);
                ctrl_d.br_ne  = (opcode_i == OPC_BNE);
            end
            OPC_JMP: begin
                ctrl_d.jump = 1'b1;
            end
            OPC_JAL: begin
                ctrl_d.jump    = 1'b1;
                ctrl_d.link    = 1'b1;
                ctrl_d.reg_we  = 1'b1;
                ctrl_d.dst_sel = DST_LINK;
            end
            default: begin
                hit_d = 1'b0;
            end
        endcase
    end

    assign ctrl_o   = ctrl_d;
    assign hit_o    = hit_d;
    assign regfmt_o = regfmt_d;
endmodule

// File: rtl/rdec_imm_ext.sv
module rdec_imm_ext
    import rdec_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned IMM_BITS = 16
) (
    input  logic [IMM_BITS-1:0] imm_i,
    input  ext_mode_e           mode_i,
    output logic [XLEN-1:0]     ext_o
);
    localparam int unsigned PAD_W = XLEN - IMM_BITS;

    logic [XLEN-1:0] ext_d;

    always_comb begin
        ext_d = '0;
        unique case (mode_i)
            EXT_ZERO:  ext_d = {{PAD_W{1'b0}}, imm_i};
            EXT_UPPER: ext_d[XLEN-1 -: IMM_BITS] = imm_i;
            default:   ext_d = {{PAD_W{imm_i[IMM_BITS-1]}}, imm_i};
        endcase
    end

    assign ext_o = ext_d;

    always_comb begin
        // R6: upper mode leaves the low part clear
        a_r6_upper_low_clear: assert (mode_i != EXT_UPPER || ext_d[PAD_W-1:0] == '0)
            else $error("upper-mode immediate has nonzero low bits");
        // R6: low part always carries the raw field outside upper mode
        a_r6_low_is_field: assert (mode_i == EXT_UPPER || ext_d[IMM_BITS-1:0] == imm_i)
            else $error("extended immediate lost its low field");
    end
endmodule

// File: rtl/risc_ctrl_decoder.sv
module risc_ctrl_decoder
    import rdec_pkg::*;
#(
    parameter int unsigned XLEN     = 32,
    parameter int unsigned LINK_IDX = 31
) (
    input  logic [INSTR_W-1:0] instr_i,
    output logic [RA_W-1:0]    rs_addr_o,
    output logic [RA_W-1:0]    rt_addr_o,
    output logic [RA_W-1:0]    dst_addr_o,
    output logic [RA_W-1:0]    shamt_o,
    output logic [XLEN-1:0]    imm_ext_o,
    output logic [TGT_W-1:0]   jtarget_o,
    output logic               reg_we_o,
    output logic [1:0]         dst_sel_o,
    output logic [2:0]         alu_op_o,
    output logic               alu_src_imm_o,
    output logic [1:0]         imm_mode_o,
    output logic               mem_rd_o,
    output logic               mem_wr_o,
    output logic               mem_byte_o,
    output logic               br_eq_o,
    output logic               br_ne_o,
    output logic               jump_o,
    output logic               jump_reg_o,
    output logic               link_o,
    output logic               illegal_o
);
    localparam logic [RA_W-1:0] LINK_ADDR = RA_W'(LINK_IDX);

    logic [OPC_W-1:0] opcode;
    logic [RA_W-1:0]  rs, rt, rd, shamt;
    logic [FN_W-1:0]  funct;
    logic [IMM_W-1:0] imm;
    logic [TGT_W-1:0] target;

    ctrl_t op_ctrl, fn_ctrl, ctrl_d;
    logic  op_hit, fn_hit, regfmt;
    logic  legal_d;
    logic [RA_W-1:0] dst_d;

    rdec_fields #(
        .INSTR_W(INSTR_W), .OPC_W(OPC_W), .FN_W(FN_W),
        .RA_W(RA_W), .IMM_W(IMM_W), .TGT_W(TGT_W)
    ) u_fields (
        .instr_i  (instr_i),
        .opcode_o (opcode),
        .rs_o     (rs),
        .rt_o     (rt),
        .rd_o     (rd),
        .shamt_o  (shamt),
        .funct_o  (funct),
        .imm_o    (imm),
        .target_o (target)
    );

    rdec_opcode_dec u_opdec (
        .opcode_i (opcode),
        .ctrl_o   (op_ctrl),
        .hit_o    (op_hit),
        .regfmt_o (regfmt)
    );

    rdec_funct_dec u_fndec (
        .funct_i (funct),
        .ctrl_o  (fn_ctrl),
        .hit_o   (fn_hit)
    );

    // Merge the two decoders; anything unrecognised collapses to idle.
    always_comb begin
        legal_d = regfmt ? fn_hit : op_hit;
        ctrl_d  = CTRL_IDLE;
        if (legal_d) begin
            ctrl_d = regfmt ? fn_ctrl : op_ctrl;
        end
        unique case (ctrl_d.dst_sel)
            DST_RT:   dst_d = rt;
            DST_LINK: dst_d = LINK_ADDR;
            default:  dst_d = rd;
        endcase
    end

    rdec_imm_ext #(
        .XLEN(XLEN), .IMM_BITS(IMM_W)
    ) u_immext (
        .imm_i  (imm),
        .mode_i (ctrl_d.ext_mode),
        .ext_o  (imm_ext_o)
    );

    assign rs_addr_o     = rs;
    assign rt_addr_o     = rt;
    assign dst_addr_o    = dst_d;
    assign shamt_o       = shamt;
    assign jtarget_o     = target;
    assign reg_we_o      = ctrl_d.reg_we;
    assign dst_sel_o     = ctrl_d.dst_sel;
    assign alu_op_o      = ctrl_d.alu_op;
    assign alu_src_imm_o = ctrl_d.alu_src_imm;
    assign imm_mode_o    = ctrl_d.ext_mode;
    assign mem_rd_o      = ctrl_d.mem_rd;
    assign mem_wr_o      = ctrl_d.mem_wr;
    assign mem_byte_o    = ctrl_d.mem_byte;
    assign br_eq_o       = ctrl_d.br_eq;
    assign br_ne_o       = ctrl_d.br_ne;
    assign jump_o        = ctrl_d.jump;
    assign jump_reg_o    = ctrl_d.jump_reg;
    assign link_o        = ctrl_d.link;
    assign illegal_o     = !legal_d;

    always_comb begin
        // R11: an illegal word has no side effect at all
        a_r11_illegal_quiet: assert (!illegal_o || !(reg_we_o | mem_rd_o | mem_wr_o |
                                      br_eq_o | br_ne_o | jump_o | jump_reg_o | link_o))
            else $error("illegal instruction drives a control flag");
        // R8: stores never write a register and never read memory
        a_r8_store_exclusive: assert (!mem_wr_o || (!reg_we_o && !mem_rd_o))
            else $error("store overlaps a register write or memory read");
        // R9: at most one control-flow change per word
        a_r9_flow_onehot: assert ($onehot0({br_eq_o, br_ne_o, jump_reg_o, jump_o & !link_o, link_o}))
            else $error("more than one control-flow flag");
        // R10: linking always writes the link register through a jump
        a_r10_link_target: assert (!link_o || (jump_o && reg_we_o && dst_addr_o == LINK_ADDR))
            else $error("link without a jump or write to the link register");
        // R1: source fields pass through untouched
        a_r1_src_fields: assert (rs_addr_o == instr_i[25:21] && rt_addr_o == instr_i[20:16])
            else $error("source register fields misplaced");
        // R7: byte size only accompanies a memory access
        a_r7_byte_needs_mem: assert (!mem_byte_o || mem_rd_o || mem_wr_o)
            else $error("byte size flagged without a memory access");
    end
endmodule

// File: tb/risc_ctrl_decoder_tb.sv
module risc_ctrl_decoder_tb;

    logic        clk = 1'b0;
    logic [31:0] instr = 32'h0;
    int          n_checks = 0;
    int          n_errors = 0;
    int          cyc = 0;
    bit          done = 1'b0;

    logic [4:0]  rs_addr, rt_addr, dst_addr, shamt;
    logic [31:0] imm_ext;
    logic [25:0] jtarget;
    logic        reg_we, alu_src_imm, mem_rd, mem_wr, mem_byte;
    logic        br_eq, br_ne, jump, jump_reg, link, illegal;
    logic [1:0]  dst_sel, imm_mode;
    logic [2:0]  alu_op;

    always #2.5 clk = ~clk;

    risc_ctrl_decoder u_dut (
        .instr_i       (instr),
        .rs_addr_o     (rs_addr),
        .rt_addr_o     (rt_addr),
        .dst_addr_o    (dst_addr),
        .shamt_o       (shamt),
        .imm_ext_o     (imm_ext),
        .jtarget_o     (jtarget),
        .reg_we_o      (reg_we),
        .dst_sel_o     (dst_sel),
        .alu_op_o      (alu_op),
        .alu_src_imm_o (alu_src_imm),
        .imm_mode_o    (imm_mode),
        .mem_rd_o      (mem_rd),
        .mem_wr_o      (mem_wr),
        .mem_byte_o    (mem_byte),
        .br_eq_o       (br_eq),
        .br_ne_o       (br_ne),
        .jump_o        (jump),
        .jump_reg_o    (jump_reg),
        .link_o        (link),
        .illegal_o     (illegal)
    );

    function automatic logic [31:0] enc_r(input logic [5:0] fn, input logic [4:0] s,
                                          input logic [4:0] t, input logic [4:0] d,
                                          input logic [4:0] sh);
        return {6'd0, s, t, d, sh, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] s,
                                          input logic [4:0] t, input logic [15:0] im);
        return {op, s, t, im};
    endfunction

    // Expected control bundle:
    // {we, dst_sel, alu, src_imm, mode, mrd, mwr, mbyte, beq, bne, jmp, jreg, link, illegal}
    function automatic logic [18:0] ev(input logic we, input logic [1:0] ds, input logic [2:0] al,
                                       input logic si, input logic [1:0] md, input logic mr,
                                       input logic mw, input logic mb, input logic be,
                                       input logic bn, input logic j, input logic jr,
                                       input logic lk, input logic il);
        return {we, ds, al, si, md, mr, mw, mb, be, bn, j, jr, lk, il};
    endfunction

    function automatic logic [18:0] act();
        return {reg_we, dst_sel, alu_op, alu_src_imm, imm_mode, mem_rd, mem_wr, mem_byte,
                br_eq, br_ne, jump, jump_reg, link, illegal};
    endfunction

    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, got, exp);
        end
    endtask

    task automatic apply(input logic [31:0] w);
        @(negedge clk);
        instr = w;
        #1;
    endtask

    task automatic t_idle_state();
        // R11: all-zero word is register format with funct 0, not in the set
        apply(32'h0);
        check("R11 zero word control", {13'd0, act()}, {13'd0, ev(0,0,0,0,0,0,0,0,0,0,0,0,0,1)});
    endtask

    task automatic t_reg_format();
        apply(enc_r(6'd32, 5'd3, 5'd4, 5'd9, 5'd0));
        check("R2 add control", {13'd0, act()}, {13'd0, ev(1,0,0,0,0,0,0,0,0,0,0,0,0,0)});
        check("R2 add dst rd", {27'd0, dst_addr}, 32'd9);
        check("R1 add rs/rt", {22'd0, rs_addr, rt_addr}, {22'd0, 5'd3, 5'd4});
        apply(enc_r(6'd34, 5'd17, 5'd18, 5'd30, 5'd0));
        check("R2 sub control", {13'd0, act()}, {13'd0, ev(1,0,1,0,0,0,0,0,0,0,0,0,0,0)});
        check("R2 sub dst rd", {27'd0, dst_addr}, 32'd30);
        apply(enc_r(6'd42, 5'd1, 5'd2, 5'd5, 5'd0));
        check("R2 slt control", {13'd0, act()}, {13'd0, ev(1,0,3,0,0,0,0,0,0,0,0,0,0,0)});
        apply(enc_r(6'd8, 5'd31, 5'd0, 5'd0, 5'd0));
        check("R3 jr control", {13'd0, act()}, {13'd0, ev(0,0,0,0,0,0,0,0,0,0,0,1,0,0)});
        check("R3 jr rs", {27'd0, rs_addr}, 32'd31);
    endtask

    task automatic t_imm_alu();
        apply(enc_i(6'd8, 5'd29, 5'd29, 16'h8004));
        check("R4 addi control", {13'd0, act()}, {13'd0, ev(1,1,0,1,0,0,0,0,0,0,0,0,0,0)});
        check("R4 addi dst rt", {27'd0, dst_addr}, 32'd29);
        check("R6 sign ext negative", imm_ext, 32'hFFFF8004);
        apply(enc_i(6'd8, 5'd1, 5'd2, 16'h7FFF));
        check("R6 sign ext positive", imm_ext, 32'h00007FFF);
        apply(enc_i(6'd10, 5'd18, 5'd8, 16'hFFF1));
        check("R4 slti control", {13'd0, act()}, {13'd0, ev(1,1,3,1,0,0,0,0,0,0,0,0,0,0)});
        check("R4 slti dst rt", {27'd0, dst_addr}, 32'd8);
        apply(enc_i(6'd13, 5'd6, 5'd7, 16'h8004));
        check("R4 ori control", {13'd0, act()}, {13'd0, ev(1,1,2,1,1,0,0,0,0,0,0,0,0,0)});
        check("R6 zero ext", imm_ext, 32'h00008004);
        apply(enc_i(6'd15, 5'd0, 5'd12, 16'hABCD));
        check("R5 lui control", {13'd0, act()}, {13'd0, ev(1,1,4,1,2,0,0,0,0,0,0,0,0,0)});
        check("R5 lui upper imm", imm_ext, 32'hABCD0000);
        check("R5 lui dst rt", {27'd0, dst_addr}, 32'd12);
    endtask

    task automatic t_memory();
        apply(enc_i(6'd35, 5'd18, 5'd8, 16'h0018));
        check("R7 lw control", {13'd0, act()}, {13'd0, ev(1,1,0,1,0,1,0,0,0,0,0,0,0,0)});
        check("R7 lw dst rt", {27'd0, dst_addr}, 32'd8);
        apply(enc_i(6'd32, 5'd19, 5'd9, 16'hFFFF));
        check("R7 lb control", {13'd0, act()}, {13'd0, ev(1,1,0,1,0,1,0,1,0,0,0,0,0,0)});
        check("R7 lb offset sign", imm_ext, 32'hFFFFFFFF);
        apply(enc_i(6'd43, 5'd19, 5'd8, 16'h0008));
        check("R8 sw control", {13'd0, act()}, {13'd0, ev(0,0,0,1,0,0,1,0,0,0,0,0,0,0)});
        apply(enc_i(6'd40, 5'd19, 5'd8, 16'h0006));
        check("R8 sb control", {13'd0, act()}, {13'd0, ev(0,0,0,1,0,0,1,1,0,0,0,0,0,0)});
    endtask

    task automatic t_flow();
        apply(enc_i(6'd4, 5'd16, 5'd17, 16'hFFFE));
        check("R9 beq control", {13'd0, act()}, {13'd0, ev(0,0,1,0,0,0,0,0,1,0,0,0,0,0)});
        check("R9 beq offset", imm_ext, 32'hFFFFFFFE);
        apply(enc_i(6'd5, 5'd16, 5'd17, 16'h0003));
        check("R9 bne control", {13'd0, act()}, {13'd0, ev(0,0,1,0,0,0,0,0,0,1,0,0,0,0)});
        apply({6'd2, 26'h2A5_5A5A});
        check("R10 j control", {13'd0, act()}, {13'd0, ev(0,0,0,0,0,0,0,0,0,0,1,0,0,0)});
        check("R1 j target", {6'd0, jtarget}, {6'd0, 26'h2A5_5A5A});
        apply({6'd3, 26'h000_09C4});
        check("R10 jal control", {13'd0, act()}, {13'd0, ev(1,2,0,0,0,0,0,0,0,0,1,0,1,0)});
        check("R10 jal dst 31", {27'd0, dst_addr}, 32'd31);
        check("R1 jal target", {6'd0, jtarget}, 32'h0000_09C4);
    endtask

    task automatic t_illegal();
        apply(enc_i(6'd6, 5'd1, 5'd2, 16'h1234));
        check("R11 opcode 6", {13'd0, act()}, {13'd0, ev(0,0,0,0,0,0,0,0,0,0,0,0,0,1)});
        apply(enc_i(6'd63, 5'd1, 5'd2, 16'h1234));
        check("R11 opcode 63", {13'd0, act()}, {13'd0, ev(0,0,0,0,0,0,0,0,0,0,0,0,0,1)});
        apply(enc_r(6'd33, 5'd4, 5'd5, 5'd6, 5'd7));
        check("R11 funct 33", {13'd0, act()}, {13'd0, ev(0,0,0,0,0,0,0,0,0,0,0,0,0,1)});
        check("R1 shamt on illegal", {27'd0, shamt}, 32'd7);
        check("R1 rs/rt on illegal", {22'd0, rs_addr, rt_addr}, {22'd0, 5'd4, 5'd5});
        apply(enc_i(6'd41, 5'd1, 5'd2, 16'h0004));
        check("R11 opcode 41", {13'd0, act()}, {13'd0, ev(0,0,0,0,0,0,0,0,0,0,0,0,0,1)});
    endtask

    initial begin
        forever begin
            @(posedge clk);
            cyc++;
            if (cyc > 5000 && !done) begin
                n_checks++;
                n_errors++;
                $display("FAIL watchdog: actual=%0d expected<=5000 cycles", cyc);
                $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
                $finish;
            end
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        t_idle_state();
        t_reg_format();
        t_imm_alu();
        t_memory();
        t_flow();
        t_illegal();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule